// File: doc/BRIEF.md
# ADC Conversion Status Tracker

This block keeps the results and status flags of an eight-channel analog-to-digital converter. Each finished conversion comes in as a single transfer that carries a channel number and a 10-bit result. The block writes that result into the channel's own data register and into a shared "latest result" register, and it updates a 32-bit read-only status word. The status word holds per-channel end-of-conversion and overrun flags, a data-ready flag, a general-overrun flag, and two bits that mirror the levels of the receive DMA engine.

Software reads through a simple port that takes an address and a read strobe. Each flag has its own clearing trigger. A channel's end-of-conversion flag clears when software reads that channel's register or the shared latest-result register. Data-ready clears when the latest-result register is read. The overrun flags clear when the status word is read. The two DMA bits are plain copies of input levels and are never latched.

The conversion input is a valid/ready stream. `conv_ready` is held high, so the block never applies back-pressure and accepts a transfer on every cycle in which `conv_valid` is high. Nothing is buffered. A result that arrives before software has collected the previous one overwrites it and raises the matching overrun flag.

Top module: `adc_status_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the status word is 0x000C0000, `rd_data` is 0, and all data registers read 0.
- R2: Status layout: bit n (0..7) is the end-of-conversion flag of channel n, bit 8+n is the overrun flag of channel n, bit 16 is data-ready, bit 17 is general-overrun, bit 18 mirrors `dma_end_rx` and bit 19 mirrors `dma_buf_full`. Bits 31:20 are always 0.
- R3: Register map by byte address: the status word at 0x1C, the latest-result register at 0x20, and channel n's register at 0x40+4n. A read returns the 10-bit result in bits 9:0 with the upper bits 0. Any other address returns 0. `rd_data` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.
- R4: Each accepted transfer sets the end-of-conversion flag of its channel and stores the result in that channel's register and in the latest-result register. Each such flag and register update shows at the first clock edge after the transfer.
- R5: A channel's end-of-conversion flag clears when that channel's register is read or when the latest-result register is read. Reading a different channel's register leaves it set.
- R6: A channel's overrun flag sets when a transfer for that channel arrives while its end-of-conversion flag is still set. All overrun flags clear when the status word is read.
- R7: Data-ready sets on every accepted transfer and clears when the latest-result register is read.
- R8: General-overrun sets when a transfer arrives while data-ready is still set, and clears when the status word is read.
- R9: Bits 18 and 19 equal the DMA input levels sampled at the previous clock edge. Both bits reset to 1.
- R10: When a set event and a clearing read fall in the same cycle, the flag ends up set.
- R11: A read of the status word returns the flag values held before that read's clearing takes effect.
- R12: `conv_ready` is 1 whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | A finished conversion is offered |
| conv_ready | output | 1 | Always high: a transfer is accepted whenever it is valid |
| conv_ch | input | 3 | Channel number of the offered result |
| conv_res | input | 10 | Conversion result |
| dma_end_rx | input | 1 | Level from the DMA engine: receive transfer finished |
| dma_buf_full | input | 1 | Level from the DMA engine: receive buffer full |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read result, registered |
| status_o | output | 32 | Live copy of the status word |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. Flag changes, stored results, the DMA mirror bits and read data all appear on `status_o` and `rd_data` after that single edge. The bench applies each stimulus at a falling edge, updates its reference model, and then compares both outputs at the next falling edge. Each comparison therefore sees the state exactly one rising edge later. Reads of the status word are checked against the model as it stood before the clearing, and this gives R11 its timing.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W        = 32;
  localparam int FLAG_SLOTS    = 8;
  localparam int BIT_OVR_BASE  = 8;
  localparam int BIT_DRDY      = 16;
  localparam int BIT_GOVR      = 17;
  localparam int BIT_ENDRX     = 18;
  localparam int BIT_BUFFULL   = 19;
  localparam int USED_BITS     = 20;
  localparam logic [7:0] OFS_STATUS    = 8'h1C;
  localparam logic [7:0] OFS_LAST      = 8'h20;
  localparam logic [7:0] OFS_CHAN_BASE = 8'h40;
  localparam logic [7:0] OFS_CHAN_STEP = 8'h04;

  typedef struct packed {
    logic status;
    logic last;
  } rd_hit_t;

  function automatic logic [7:0] chan_ofs(input int idx);
    return OFS_CHAN_BASE + 8'(idx) * OFS_CHAN_STEP;
  endfunction
endpackage

// File: rtl/adc_chan_bank.sv
module adc_chan_bank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        conv_fire,
  input  logic [CH_W-1:0]             conv_ch,
  input  logic [RES_W-1:0]            conv_res,
  input  logic [NUM_CH-1:0]           rd_chan,
  input  adc_stat_pkg::rd_hit_t       rd_hit,
  output logic [NUM_CH-1:0][RES_W-1:0] chan_data,
  output logic [NUM_CH-1:0]           eoc,
  output logic [NUM_CH-1:0]           ovre
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = conv_fire && (conv_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chan_data[g] <= '0;
        eoc[g]       <= 1'b0;
        ovre[g]      <= 1'b0;
      end else begin
        if (hit) chan_data[g] <= conv_res;
        // a new result wins over any clearing read in the same cycle
        eoc[g]  <= hit || (eoc[g] && !rd_chan[g] && !rd_hit.last);
        ovre[g] <= (hit && eoc[g]) || (ovre[g] && !rd_hit.status);
      end
    end
  end
endmodule

// File: rtl/adc_last_reg.sv
module adc_last_reg #(
  parameter int RES_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_fire,
  input  logic [RES_W-1:0]      conv_res,
  input  adc_stat_pkg::rd_hit_t rd_hit,
  output logic [RES_W-1:0]      last_data,
  output logic                  drdy,
  output logic                  govre
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_data <= '0;
      drdy      <= 1'b0;
      govre     <= 1'b0;
    end else begin
      if (conv_fire) last_data <= conv_res;
      drdy  <= conv_fire || (drdy && !rd_hit.last);
      govre <= (conv_fire && drdy) || (govre && !rd_hit.status);
    end
  end
endmodule

// File: rtl/adc_dma_mirror.sv
module adc_dma_mirror (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_end_rx,
  input  logic dma_buf_full,
  output logic endrx_q,
  output logic buffull_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      endrx_q   <= 1'b1;
      buffull_q <= 1'b1;
    end else begin
      endrx_q   <= dma_end_rx;
      buffull_q <= dma_buf_full;
    end
  end
endmodule

// File: rtl/adc_read_port.sv
module adc_read_port #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [31:0]                  status_word,
  input  logic [RES_W-1:0]             last_data,
  input  logic [NUM_CH-1:0][RES_W-1:0] chan_data,
  output adc_stat_pkg::rd_hit_t        rd_hit,
  output logic [NUM_CH-1:0]            rd_chan,
  output logic [31:0]                  rd_data
);
  import adc_stat_pkg::*;

  assign rd_hit.status = rd_en && (rd_addr == ADDR_W'(OFS_STATUS));
  assign rd_hit.last   = rd_en && (rd_addr == ADDR_W'(OFS_LAST));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign rd_chan[g] = rd_en && (rd_addr == ADDR_W'(chan_ofs(g)));
  end

  logic [31:0] sel;
  always_comb begin
    sel = '0;
    if (rd_hit.status) sel = status_word;
    if (rd_hit.last)   sel = 32'(last_data);
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_chan[i]) sel = 32'(chan_data[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/adc_status_tracker.sv
module adc_status_tracker #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_res,
  input  logic              dma_end_rx,
  input  logic              dma_buf_full,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [31:0]       status_o
);
  import adc_stat_pkg::*;

  logic                         conv_fire;
  logic [NUM_CH-1:0][RES_W-1:0] chan_data;
  logic [NUM_CH-1:0]            eoc, ovre, rd_chan;
  logic [RES_W-1:0]             last_data;
  logic                         drdy, govre, endrx_q, buffull_q;
  rd_hit_t                      rd_hit;
  logic [FLAG_SLOTS-1:0]        eoc_w, ovre_w;

  assign conv_ready = 1'b1;
  assign conv_fire  = conv_valid && conv_ready;

  adc_chan_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .conv_fire(conv_fire), .conv_ch(conv_ch),
    .conv_res(conv_res), .rd_chan(rd_chan), .rd_hit(rd_hit),
    .chan_data(chan_data), .eoc(eoc), .ovre(ovre));

  adc_last_reg #(.RES_W(RES_W)) last_i (
    .clk(clk), .rst_n(rst_n), .conv_fire(conv_fire), .conv_res(conv_res),
    .rd_hit(rd_hit), .last_data(last_data), .drdy(drdy), .govre(govre));

  adc_dma_mirror dma_i (
    .clk(clk), .rst_n(rst_n), .dma_end_rx(dma_end_rx),
    .dma_buf_full(dma_buf_full), .endrx_q(endrx_q), .buffull_q(buffull_q));

  always_comb begin
    eoc_w  = '0;
    ovre_w = '0;
    eoc_w[NUM_CH-1:0]  = eoc;
    ovre_w[NUM_CH-1:0] = ovre;
  end

  always_comb begin
    status_o = '0;
    status_o[FLAG_SLOTS-1:0]                       = eoc_w;
    status_o[BIT_OVR_BASE +: FLAG_SLOTS]           = ovre_w;
    status_o[BIT_DRDY]                             = drdy;
    status_o[BIT_GOVR]                             = govre;
    status_o[BIT_ENDRX]                            = endrx_q;
    status_o[BIT_BUFFULL]                          = buffull_q;
  end

  adc_read_port #(.NUM_CH(NUM_CH), .RES_W(RES_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .status_word(status_o), .last_data(last_data), .chan_data(chan_data),
    .rd_hit(rd_hit), .rd_chan(rd_chan), .rd_data(rd_data));
endmodule

// File: rtl/adc_status_tracker_chk.sv
module adc_status_tracker_chk #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic [CH_W-1:0]   conv_ch,
  input logic              dma_end_rx,
  input logic              dma_buf_full,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       status_o
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:20] == 12'h000);

  assert_eoc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> status_o[$past(conv_ch)]);

  assert_ovre_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && status_o[conv_ch]) |=> status_o[8 + int'($past(conv_ch))]);

  assert_drdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> status_o[16]);

  assert_drdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(8'h20) && !conv_valid) |=> !status_o[16]);

  assert_govre_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && status_o[16]) |=> status_o[17]);

  assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(8'h1C) && !conv_valid) |=> (status_o[15:8] == 8'h00 && !status_o[17]));

  assert_dma_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[18] == $past(dma_end_rx) && status_o[19] == $past(dma_buf_full)));

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready);
endmodule

bind adc_status_tracker adc_status_tracker_chk #(
  .NUM_CH(NUM_CH), .RES_W(RES_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
  .conv_ch(conv_ch), .dma_end_rx(dma_end_rx), .dma_buf_full(dma_buf_full),
  .rd_en(rd_en), .rd_addr(rd_addr), .status_o(status_o));

// File: tb/adc_status_tracker_tb_top.sv
module adc_status_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic        conv_ready;
  logic [2:0]  conv_ch = '0;
  logic [9:0]  conv_res = '0;
  logic        dma_end_rx = 1'b0;
  logic        dma_buf_full = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] status_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_ch(conv_ch), .conv_res(conv_res), .dma_end_rx(dma_end_rx),
    .dma_buf_full(dma_buf_full), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_o(status_o));

  // reference model
  logic [9:0] m_chan [8];
  logic [9:0] m_last;
  logic [7:0] m_eoc, m_ovre;
  logic       m_drdy, m_govre, m_endrx, m_buff;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_status();
    return {12'h000, m_buff, m_endrx, m_govre, m_drdy, m_ovre, m_eoc};
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h1C) return m_status();
    if (a == 8'h20) return {22'h0, m_last};
    for (int n = 0; n < 8; n++)
      if (a == 8'h40 + 8'(4 * n)) return {22'h0, m_chan[n]};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, update the model,
  // then compare both outputs one rising edge later
  task automatic step(input bit cv, input int ch, input int res, input bit re,
                      input logic [7:0] a, input bit de, input bit db, input string tag);
    logic [7:0] n_eoc, n_ovre;
    logic n_drdy, n_govre;
    conv_valid = cv; conv_ch = 3'(ch); conv_res = 10'(res);
    rd_en = re; rd_addr = a; dma_end_rx = de; dma_buf_full = db;
    if (re) m_rd = m_read(a);
    n_eoc = m_eoc; n_ovre = m_ovre; n_drdy = m_drdy; n_govre = m_govre;
    if (re && a == 8'h1C) begin n_ovre = '0; n_govre = 1'b0; end
    if (re && a == 8'h20) begin n_eoc = '0; n_drdy = 1'b0; end
    for (int n = 0; n < 8; n++)
      if (re && a == 8'h40 + 8'(4 * n)) n_eoc[n] = 1'b0;
    if (cv) begin
      if (m_eoc[ch]) n_ovre[ch] = 1'b1;
      if (m_drdy) n_govre = 1'b1;
      n_eoc[ch] = 1'b1; n_drdy = 1'b1;
      m_chan[ch] = 10'(res); m_last = 10'(res);
    end
    m_eoc = n_eoc; m_ovre = n_ovre; m_drdy = n_drdy; m_govre = n_govre;
    m_endrx = de; m_buff = db;
    @(negedge clk);
    chk({tag, " status"}, status_o, m_status());
    chk({tag, " rd_data"}, rd_data, m_rd);
    chk("R12 ready", {31'h0, conv_ready}, 32'h1);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 8'h00, m_endrx, m_buff, tag);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) m_chan[n] = '0;
    m_last = '0; m_eoc = '0; m_ovre = '0; m_drdy = 0; m_govre = 0;
    m_endrx = 1; m_buff = 1; m_rd = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_o, 32'h000C0000);
    chk("R1 reset rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    // reads right after reset: data registers are zero
    step(0, 0, 0, 1, 8'h20, 1, 1, "R1 last after reset");
    step(0, 0, 0, 1, 8'h4C, 1, 1, "R1 ch3 after reset");
    step(0, 0, 0, 1, 8'h1C, 1, 1, "R1 status read");
    chk("R1 status value", rd_data, 32'h000C0000);
    // R4/R7: conversion on channel 3
    step(1, 3, 'h2A5, 0, 8'h00, 1, 1, "R4 conv ch3");
    chk("R4 eoc3", {31'h0, status_o[3]}, 32'h1);
    chk("R7 drdy", {31'h0, status_o[16]}, 32'h1);
    // R5: reading another channel leaves eoc3 set
    step(0, 0, 0, 1, 8'h44, 1, 1, "R5 read ch1");
    chk("R5 eoc3 kept", {31'h0, status_o[3]}, 32'h1);
    step(0, 0, 0, 1, 8'h4C, 1, 1, "R3 read ch3");
    chk("R3 ch3 data", rd_data, 32'h2A5);
    chk("R5 eoc3 cleared", {31'h0, status_o[3]}, 32'h0);
    chk("R7 drdy kept", {31'h0, status_o[16]}, 32'h1);
    step(0, 0, 0, 1, 8'h20, 1, 1, "R7 read last");
    chk("R3 last data", rd_data, 32'h2A5);
    chk("R7 drdy cleared", {31'h0, status_o[16]}, 32'h0);
    step(0, 0, 0, 1, 8'h04, 1, 1, "R3 unmapped");
    chk("R3 unmapped zero", rd_data, 32'h0);
    // R5: latest-result read clears every channel's eoc
    step(1, 5, 'h3FF, 0, 8'h00, 1, 1, "R4 conv ch5");
    step(0, 0, 0, 1, 8'h20, 1, 1, "R5 last clears eoc");
    chk("R5 eoc5 cleared by last", {31'h0, status_o[5]}, 32'h0);
    // R6/R8: back-to-back on channel 1
    step(1, 1, 'h011, 0, 8'h00, 1, 1, "R6 first");
    step(1, 1, 'h022, 0, 8'h00, 1, 1, "R6 second");
    chk("R6 ovre1", {31'h0, status_o[9]}, 32'h1);
    chk("R8 govre", {31'h0, status_o[17]}, 32'h1);
    step(0, 0, 0, 1, 8'h1C, 1, 1, "R11 status read");
    chk("R11 pre-clear value", rd_data & 32'h0002_0200, 32'h0002_0200);
    chk("R6 ovre cleared", {24'h0, status_o[15:8]}, 32'h0);
    chk("R8 govre cleared", {31'h0, status_o[17]}, 32'h0);
    // R10: set and clear in the same cycle
    step(1, 2, 'h155, 1, 8'h20, 1, 1, "R10 last read+conv");
    chk("R10 eoc2 set", {31'h0, status_o[2]}, 32'h1);
    chk("R10 drdy set", {31'h0, status_o[16]}, 32'h1);
    step(1, 2, 'h0AA, 1, 8'h1C, 1, 1, "R10 status read+ovr");
    chk("R10 ovre2 set", {31'h0, status_o[10]}, 32'h1);
    chk("R10 govre set", {31'h0, status_o[17]}, 32'h1);
    // R9: DMA levels
    step(0, 0, 0, 0, 8'h00, 0, 1, "R9 endrx low");
    chk("R9 endrx", {30'h0, status_o[19:18]}, 32'h2);
    step(0, 0, 0, 0, 8'h00, 1, 0, "R9 buffull low");
    chk("R9 buffull", {30'h0, status_o[19:18]}, 32'h1);
    // random mix, checked against the model every cycle (R2, R10, R11)
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom_range(0, 11);
      if (sel < 8) a = 8'h40 + 8'(4 * sel);
      else if (sel == 8) a = 8'h1C;
      else if (sel == 9) a = 8'h20;
      else a = 8'($urandom_range(0, 255));
      step($urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 1023),
           $urandom_range(0, 1) == 1, a, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, "R2 random");
    end
    idle("R2 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule